// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block keeps two copies of a set of byte-wide configuration registers. A host writes bytes through a simple write port into a buffer copy. That copy has no effect on the rest of the chip. The active copy feeds the datapath, and it takes the buffer contents only when an update transfer happens. The transfer is synchronous to the system clock and copies every byte in a single cycle. A whole group of related settings therefore changes at once.

The transfer trigger comes from one of two sources. The first is an internal rate counter, whose period is set by the lowest register bytes. In this mode the block also drives the update pin as an output. The second is an external strobe on the same pin, which passes through a synchronizer and an edge detector. The source select bit sits in the control byte, and like every other setting it only takes effect through a transfer. Out of reset the source is internal, so a host that wants external updates programs that choice and waits for the first internal transfer.

The control byte also carries three other bits. One is a self-clearing accumulator-clear strobe, which lasts one cycle in the active copy while the buffer keeps it. The other two are level-type configuration bits.

Top module: `regbank_dbuf`

## Requirements
- R1: While `rst` is high, both copies load their defaults. The rate bytes (addresses 0 to RATE_BYTES-1, little-endian) hold DEF_RATE. The control byte (address RATE_BYTES) holds 0x01. All other bytes hold 0x00. Host writes during reset are dropped.
- R2: A host write changes only the buffer copy. `act_bank_o` keeps its value in every cycle that does not follow a transfer, apart from the self-clearing strobe bit.
- R3: `xfer_o` is high for the cycle before the clock edge that copies all buffer bytes into the active copy. From the next cycle, `act_bank_o` equals the buffer contents sampled at that edge. Byte i sits at bits [8i+7:8i].
- R4: In internal mode, the first transfer happens in the first cycle after reset. After that, a transfer happens every N+1 cycles, where N is the rate value loaded at the previous transfer. `upd_pin_oe` is high and `upd_pin_o` mirrors `xfer_o`.
- R5: In external mode, `upd_pin_oe` is low. A rising edge on `upd_pin_i` raises `xfer_o` in the cycle after the second clock edge that samples the pin high. Each rise gives exactly one transfer, however long the pin stays high. Without a rise, no transfer happens.
- R6: Control bit 0 selects the source (1 = internal, 0 = external). A changed value reaches `int_mode_o` only through a transfer.
- R7: Control bit 1 is a one-shot. After each transfer that carries a 1, `clr_acc_o` is high for exactly one cycle. The buffer keeps the 1, so later transfers repeat the pulse.
- R8: Control bit 2 (`hold_clr_o`) and control bit 3 (`lsb_first_o`) are levels. Each follows the active copy and changes only through a transfer.
- R9: A write in the same cycle as a transfer lands in the buffer. The ongoing transfer carries the old byte, and the next transfer carries the new one.
- R10: Writes to addresses at or above NUM_BYTES leave both copies unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | ADDR_W | Host byte address |
| wr_data | input | 8 | Host write data |
| upd_pin_i | input | 1 | External update strobe from the pad |
| upd_pin_o | output | 1 | Update pulse driven onto the pad in internal mode |
| upd_pin_oe | output | 1 | Pad output enable, high in internal mode |
| xfer_o | output | 1 | High in the cycle before a buffer-to-active copy |
| act_bank_o | output | NUM_BYTES*8 | Active copy, byte i at bits [8i+7:8i] |
| int_mode_o | output | 1 | Active source select, 1 = internal |
| clr_acc_o | output | 1 | One-cycle accumulator clear strobe |
| hold_clr_o | output | 1 | Level-type clear-hold setting |
| lsb_first_o | output | 1 | Level-type bit order setting |

## Verification
The bench builds the block with six bytes, four rate bytes and a default rate of 5. The internal period out of reset is therefore only six cycles. Reprogramming the rate to 2 or 3 shows within a few cycles whether the new period starts at the very next interval. With six bytes the address port is three bits wide, so addresses 6 and 7 exist on the port but map to no byte. This makes the ignored-write requirement reachable. Timing a write onto the exact cycle of an externally triggered transfer exercises the write-versus-copy collision.

// File: rtl/regbank_dbuf_pkg.sv
package regbank_dbuf_pkg;

    // Low nibble of the control byte; bit 0 is the source select.
    typedef struct packed {
        logic lsb_first;
        logic hold_clr;
        logic clr_pulse;
        logic int_upd;
    } ctrl_t;

    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int CLR_BIT  = 1;
    localparam logic [7:0] CTRL_DEFAULT = 8'h01;

    // Reset value of byte idx of the bank.
    function automatic logic [7:0] default_byte(input int idx,
                                                input int rate_bytes,
                                                input logic [63:0] def_rate);
        logic [7:0] b;
        if (idx < rate_bytes)
            b = def_rate[idx*8 +: 8];
        else if (idx == rate_bytes)
            b = CTRL_DEFAULT;
        else
            b = 8'h00;
        return b;
    endfunction

endpackage

// File: rtl/regbank_dbuf_timer.sv
module regbank_dbuf_timer #(
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] reload,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/regbank_dbuf_edge_sync.sv
module regbank_dbuf_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic enable,
    output logic pulse
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign pulse = enable && sync_q && !last_q;
endmodule

// File: rtl/regbank_dbuf_bank.sv
module regbank_dbuf_bank
    import regbank_dbuf_pkg::*;
#(
    parameter int          NUM_BYTES  = 12,
    parameter int          RATE_BYTES = 4,
    parameter logic [63:0] DEF_RATE   = 64'd64,
    parameter int          ADDR_W     = 4,
    localparam int         BANK_W     = NUM_BYTES * 8,
    localparam int         RATE_W     = RATE_BYTES * 8,
    localparam int         CTRL_IDX   = RATE_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              xfer,
    output logic [RATE_W-1:0] rate_sh_o,
    output logic [BANK_W-1:0] active_o
);
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        localparam logic [7:0] DEF = default_byte(i, RATE_BYTES, DEF_RATE);
        logic [7:0] sh_q;
        logic [7:0] act_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q <= DEF;
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                sh_q <= wr_data;
            end
        end

        if (i == CTRL_IDX) begin : g_ctrl
            // One-shot bit falls back to zero in the active copy only.
            always_ff @(posedge clk) begin
                if (rst) begin
                    act_q <= DEF;
                end else if (xfer) begin
                    act_q <= sh_q;
                end else begin
                    act_q[CLR_BIT] <= 1'b0;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    act_q <= DEF;
                end else if (xfer) begin
                    act_q <= sh_q;
                end
            end
        end

        if (i < RATE_BYTES) begin : g_rate
            assign rate_sh_o[i*8 +: 8] = sh_q;
        end

        assign active_o[i*8 +: 8] = act_q;
    end
endmodule

// File: rtl/regbank_dbuf.sv
module regbank_dbuf
    import regbank_dbuf_pkg::*;
#(
    parameter int          NUM_BYTES  = 12,
    parameter int          RATE_BYTES = 4,
    parameter logic [63:0] DEF_RATE   = 64'd64,
    parameter int          ADDR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic                   upd_pin_i,
    output logic                   upd_pin_o,
    output logic                   upd_pin_oe,
    output logic                   xfer_o,
    output logic [NUM_BYTES*8-1:0] act_bank_o,
    output logic                   int_mode_o,
    output logic                   clr_acc_o,
    output logic                   hold_clr_o,
    output logic                   lsb_first_o
);
    localparam int RATE_W   = RATE_BYTES * 8;
    localparam int CTRL_IDX = RATE_BYTES;

    logic [RATE_W-1:0]      rate_sh;
    logic [NUM_BYTES*8-1:0] act_bank;
    ctrl_t                  act_ctrl;
    logic                   int_tick;
    logic                   ext_tick;
    logic                   xfer;

    assign act_ctrl = ctrl_t'(act_bank[CTRL_IDX*8 +: CTRL_W]);

    // Internal timer reloads with the rate being transferred at its own tick.
    regbank_dbuf_timer #(.RATE_W(RATE_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (act_ctrl.int_upd),
        .reload (rate_sh),
        .tick   (int_tick)
    );

    regbank_dbuf_edge_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (upd_pin_i),
        .enable (!act_ctrl.int_upd),
        .pulse  (ext_tick)
    );

    assign xfer = !rst && (int_tick || ext_tick);

    regbank_dbuf_bank #(
        .NUM_BYTES  (NUM_BYTES),
        .RATE_BYTES (RATE_BYTES),
        .DEF_RATE   (DEF_RATE),
        .ADDR_W     (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .xfer      (xfer),
        .rate_sh_o (rate_sh),
        .active_o  (act_bank)
    );

    assign xfer_o      = xfer;
    assign act_bank_o  = act_bank;
    assign int_mode_o  = act_ctrl.int_upd;
    assign clr_acc_o   = act_ctrl.clr_pulse;
    assign hold_clr_o  = act_ctrl.hold_clr;
    assign lsb_first_o = act_ctrl.lsb_first;
    assign upd_pin_oe  = act_ctrl.int_upd;
    assign upd_pin_o   = act_ctrl.int_upd && int_tick && !rst;
endmodule

// File: rtl/regbank_dbuf_chk.sv
module regbank_dbuf_chk #(
    parameter int NUM_BYTES  = 12,
    parameter int RATE_BYTES = 4,
    localparam int BANK_W    = NUM_BYTES * 8
) (
    input logic              clk,
    input logic              rst,
    input logic              xfer_o,
    input logic              int_mode_o,
    input logic              upd_pin_o,
    input logic              upd_pin_oe,
    input logic              clr_acc_o,
    input logic [BANK_W-1:0] act_bank_o
);
    localparam logic [BANK_W-1:0] KEEP =
        ~(BANK_W'(1) << (RATE_BYTES * 8 + regbank_dbuf_pkg::CLR_BIT));

    // R2: no change to the active copy without a preceding transfer
    p_hold_between_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(xfer_o) |-> $stable(act_bank_o & KEEP));

    // R4: internal mode drives the pad with the transfer pulse
    p_pin_mirror_r4: assert property (@(posedge clk) disable iff (rst)
        int_mode_o |-> (upd_pin_oe && (upd_pin_o == xfer_o)));

    // R5: external mode releases the pad and gives single-cycle transfers
    p_ext_release_r5: assert property (@(posedge clk) disable iff (rst)
        !int_mode_o |-> !upd_pin_oe);

    p_ext_single_r5: assert property (@(posedge clk) disable iff (rst)
        (!int_mode_o && xfer_o) |=> (!xfer_o || int_mode_o));

    // R6: source select changes only through a transfer
    p_mode_on_xfer_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(int_mode_o) |-> $past(xfer_o));

    // R7: the clear strobe only follows a transfer
    p_oneshot_r7: assert property (@(posedge clk) disable iff (rst)
        clr_acc_o |-> $past(xfer_o));
endmodule

bind regbank_dbuf regbank_dbuf_chk #(
    .NUM_BYTES  (NUM_BYTES),
    .RATE_BYTES (RATE_BYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .xfer_o     (xfer_o),
    .int_mode_o (int_mode_o),
    .upd_pin_o  (upd_pin_o),
    .upd_pin_oe (upd_pin_oe),
    .clr_acc_o  (clr_acc_o),
    .act_bank_o (act_bank_o)
);

// File: tb/regbank_dbuf_tb_top.sv
module regbank_dbuf_tb_top;
    localparam int NB = 6;
    localparam int RB = 4;
    localparam int AW = 3;
    localparam int BW = NB * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          upd_pin_i = 1'b0;
    logic          upd_pin_o, upd_pin_oe, xfer_o;
    logic [BW-1:0] act_bank_o;
    logic          int_mode_o, clr_acc_o, hold_clr_o, lsb_first_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] sh_exp [NB];

    always #2 clk = ~clk;

    regbank_dbuf #(
        .NUM_BYTES  (NB),
        .RATE_BYTES (RB),
        .DEF_RATE   (64'd5)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .upd_pin_i   (upd_pin_i),
        .upd_pin_o   (upd_pin_o),
        .upd_pin_oe  (upd_pin_oe),
        .xfer_o      (xfer_o),
        .act_bank_o  (act_bank_o),
        .int_mode_o  (int_mode_o),
        .clr_acc_o   (clr_acc_o),
        .hold_clr_o  (hold_clr_o),
        .lsb_first_o (lsb_first_o)
    );

    function automatic logic [BW-1:0] sh_vec();
        logic [BW-1:0] v;
        for (int i = 0; i < NB; i++) v[i*8 +: 8] = sh_exp[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NB; i++) sh_exp[i] = 8'h00;
        sh_exp[0]  = 8'h05;
        sh_exp[RB] = 8'h01;
    endtask

    // Drives at the current negedge, released at the next one.
    task automatic host_wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (!rst && int'(a) < NB) sh_exp[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_xfer();
        do @(negedge clk); while (!xfer_o);
    endtask

    // Called at a negedge showing xfer_o high; counts cycles to the next.
    task automatic period_is(input int exp, input string req);
        int n = 0;
        do begin @(negedge clk); n++; end while (!xfer_o && n < 100);
        chk(n == exp, req, n, exp);
    endtask

    task automatic ext_pulse();
        upd_pin_i = 1'b1;
        repeat (3) @(negedge clk);
        upd_pin_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        model_reset();
        host_wr(3'd5, 8'hFF);     // dropped: in reset
        repeat (10) @(negedge clk);
        chk(act_bank_o == sh_vec(), "R1 defaults", act_bank_o, sh_vec());
        chk(int_mode_o && !clr_acc_o && !hold_clr_o && !lsb_first_o,
            "R1 ctrl defaults", {int_mode_o, clr_acc_o, hold_clr_o, lsb_first_o}, 4'b1000);
        chk(!xfer_o, "R1 no transfer in reset", xfer_o, 0);
    endtask

    task automatic t_first_tick_and_invisible();
        rst = 1'b0;
        #1;
        chk(xfer_o && upd_pin_o && upd_pin_oe, "R4 first tick after reset",
            {xfer_o, upd_pin_o, upd_pin_oe}, 3'b111);
        @(negedge clk);
        chk(act_bank_o == sh_vec(), "R1 reset write dropped", act_bank_o, sh_vec());
        host_wr(3'd5, 8'hA5);
        chk(act_bank_o[47:40] == 8'h00, "R2 write not visible", act_bank_o[47:40], 0);
        wait_xfer();
        chk(act_bank_o[47:40] == 8'h00, "R2 still hidden before copy", act_bank_o[47:40], 0);
        @(negedge clk);
        chk(act_bank_o == sh_vec(), "R3 copy after transfer", act_bank_o, sh_vec());
    endtask

    task automatic t_rate_change();
        host_wr(3'd0, 8'h02);
        wait_xfer();
        period_is(3, "R4 new period right after copy");
        period_is(3, "R4 period repeats");
    endtask

    task automatic t_oneshot();
        @(negedge clk);
        host_wr(3'd4, 8'h03);
        wait_xfer();
        chk(!clr_acc_o, "R7 no strobe before copy", clr_acc_o, 0);
        @(negedge clk);
        chk(clr_acc_o, "R7 strobe after copy", clr_acc_o, 1);
        @(negedge clk);
        chk(!clr_acc_o, "R7 strobe one cycle", clr_acc_o, 0);
        wait_xfer();
        @(negedge clk);
        chk(clr_acc_o, "R7 buffer kept bit, strobe repeats", clr_acc_o, 1);
        @(negedge clk);
        chk(!clr_acc_o, "R7 repeat strobe one cycle", clr_acc_o, 0);
    endtask

    task automatic t_levels();
        host_wr(3'd4, 8'h0D);
        chk(!hold_clr_o && !lsb_first_o, "R8 levels wait for copy",
            {hold_clr_o, lsb_first_o}, 0);
        wait_xfer();
        @(negedge clk);
        repeat (2) @(negedge clk);
        chk(hold_clr_o && lsb_first_o && !clr_acc_o, "R8 levels held",
            {hold_clr_o, lsb_first_o, clr_acc_o}, 3'b110);
    endtask

    task automatic t_to_external();
        int cnt = 0;
        wait_xfer();
        @(negedge clk);
        host_wr(3'd4, 8'h00);
        chk(int_mode_o, "R6 select waits for copy", int_mode_o, 1);
        wait_xfer();
        chk(int_mode_o, "R6 still internal at copy cycle", int_mode_o, 1);
        @(negedge clk);
        chk(!int_mode_o && !upd_pin_oe, "R6 external after copy",
            {int_mode_o, upd_pin_oe}, 0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (xfer_o) cnt++;
        end
        chk(cnt == 0, "R5 no transfer without pin edge", cnt, 0);
    endtask

    task automatic t_ext_pulse();
        int cnt = 0;
        int first = 0;
        host_wr(3'd5, 8'h3C);
        upd_pin_i = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (xfer_o) begin
                cnt++;
                if (first == 0) first = k;
            end
        end
        upd_pin_i = 1'b0;
        chk(cnt == 1, "R5 one transfer per rise", cnt, 1);
        chk(first == 2, "R5 transfer latency", first, 2);
        chk(act_bank_o[47:40] == 8'h3C, "R3 external copy", act_bank_o[47:40], 8'h3C);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_collision();
        host_wr(3'd5, 8'h11);
        upd_pin_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(xfer_o, "R9 transfer cycle reached", xfer_o, 1);
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h22;
        @(negedge clk);
        wr_en = 1'b0;
        sh_exp[5] = 8'h22;
        chk(act_bank_o[47:40] == 8'h11, "R9 copy carries old byte", act_bank_o[47:40], 8'h11);
        upd_pin_i = 1'b0;
        repeat (3) @(negedge clk);
        ext_pulse();
        chk(act_bank_o[47:40] == 8'h22, "R9 next copy carries new byte", act_bank_o[47:40], 8'h22);
    endtask

    task automatic t_out_of_range();
        host_wr(3'd6, 8'hFF);
        host_wr(3'd7, 8'hEE);
        ext_pulse();
        chk(act_bank_o == sh_vec(), "R10 out-of-range writes ignored", act_bank_o, sh_vec());
    endtask

    task automatic t_back_internal();
        host_wr(3'd0, 8'h03);
        host_wr(3'd4, 8'h01);
        upd_pin_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        upd_pin_i = 1'b0;
        chk(int_mode_o && upd_pin_oe, "R6 internal restored", {int_mode_o, upd_pin_oe}, 2'b11);
        chk(xfer_o && upd_pin_o, "R4 tick on entering internal", {xfer_o, upd_pin_o}, 2'b11);
        period_is(4, "R4 period with rate 3");
    endtask

    task automatic t_mid_reset();
        rst = 1'b1;
        model_reset();
        repeat (12) @(negedge clk);
        chk(act_bank_o == sh_vec(), "R1 defaults after mid-run reset", act_bank_o, sh_vec());
        rst = 1'b0;
        @(negedge clk);
        period_is(5, "R4 default period after reset");
    endtask

    initial begin
        t_reset_state();
        t_first_tick_and_invisible();
        t_rate_change();
        t_oneshot();
        t_levels();
        t_to_external();
        t_ext_pulse();
        t_collision();
        t_out_of_range();
        t_back_internal();
        t_mid_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule